// File: doc/BRIEF.md
# Receive Cluster DMA Engine with Circular Pointer Table

This block is one receive DMA channel. Incoming packet data is written into memory clusters. The base address of each cluster comes from a circular table in memory. Each table entry is a pair of qwords: a cluster pointer, then a status word. The engine keeps its table position on the status slot of the current entry. It always holds the pointer of the next cluster, fetched ahead of time, so that a new packet can start without waiting for a table read.

Software sets three values before the channel is started: the table base, the cluster limit in qwords, and the table length in qwords. After a `start` pulse, a receive MAC drives the engine with five commands: save head, skip, write next, write status and interrupt. The engine performs all 64-bit memory accesses through a request/acknowledge port. The current table position is visible at all times on `tbl_pos`.

Top module: `rx_cluster_dma`

## Requirements
- R1: A `start` pulse in the idle state reads the qword at `cfg_tbl_base`. That value becomes the active cluster write pointer, and `tbl_pos` becomes base + 8.
- R2: Right after the first read, the engine prefetches the next cluster pointer from `tbl_pos` + 8. `tbl_pos` does not move.
- R3: Command SAVE (`cmd_op` = 1) copies the active cluster write pointer to `head_ptr`.
- R4: Command SKIP (`cmd_op` = 2) advances the cluster write pointer by 8 and increments the qword count, without any memory access.
- R5: Command NEXT (`cmd_op` = 3) writes `cmd_data` at the cluster write pointer, then advances the pointer by 8 and increments the count. A memory request holds its address until `mem_ack`.
- R6: Command STAT (`cmd_op` = 4) writes `cmd_data` with bit 3 forced to 1 at `tbl_pos`, then advances `tbl_pos` by 16.
- R7: The first NEXT after a STAT writes a zero qword, whatever the value of `cmd_data`.
- R8: Command INTR (`cmd_op` = 5) sets `irq` and makes the prefetched pointer the active cluster pointer. It resets the qword count to 0 and reads the following pointer at `tbl_pos` + 8.
- R9: Every table position and prefetch address wraps modulo 8 × `cfg_tbl_qwords`, relative to `cfg_tbl_base`.
- R10: A NEXT or SKIP issued when the count already equals `cfg_clu_limit` makes no memory access and does not move the pointer. It sets `ovf`, and the command is still acknowledged.
- R11: `irq` and `ovf` stay set until a one-cycle `irq_clr` pulse clears both. If a set and a clear happen in the same cycle, the set wins.
- R12: Any other `cmd_op` value is acknowledged and has no effect on memory, `head_ptr` or `tbl_pos`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin channel operation (idle state only) |
| irq_clr | input | 1 | Write-1 clear of `irq` and `ovf` |
| cfg_tbl_base | input | AW | Byte address of the pointer table |
| cfg_clu_limit | input | CW | Cluster capacity in qwords |
| cfg_tbl_qwords | input | CW | Table length in qwords (even, at least 4) |
| cmd_valid | input | 1 | Command present; held until `cmd_ack` |
| cmd_op | input | 3 | Command code |
| cmd_data | input | 64 | Data or status qword for the command |
| cmd_ack | output | 1 | Command finished in this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Access done; read data valid |
| mem_rdata | input | 64 | Read data |
| tbl_pos | output | AW | Current table position |
| head_ptr | output | AW | Head pointer saved for the last packet |
| irq | output | 1 | Channel interrupt flag |
| ovf | output | 1 | Cluster overflow flag |

## Verification
A scoreboard holds every memory access the engine should make. The stimulus covers four cases:
- A short packet with a skip, data writes, status and the trailing zero write shows whether pointer steps and forced bits are right.
- A packet that overruns its cluster shows that writes are suppressed at the limit. Because it follows a packet that ended exactly at the limit, it also shows whether the count resets when a new cluster is loaded.
- Two further packets move the table past its end, so the wrap of both the prefetch address and the status address is seen at `tbl_pos` and on the bus.
- Unused command codes between packets must leave no memory access and no change in state.

// File: rtl/rxcd_pkg.sv
package rxcd_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_SAVE = 3'd1,
    OP_SKIP = 3'd2,
    OP_NEXT = 3'd3,
    OP_STAT = 3'd4,
    OP_INTR = 3'd5
  } rxcd_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_PREF,
    ST_RUN,
    ST_WDATA,
    ST_WSTAT
  } rxcd_state_e;

  // status qword with the completion marker bit forced on
  function automatic logic [63:0] stat_word(input logic [63:0] raw);
    return raw | 64'h8;
  endfunction

endpackage

// File: rtl/rxcd_tbl_walker.sv
module rxcd_tbl_walker #(
  parameter int AW = 64,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] qwords,
  input  logic          ld_base,
  input  logic          adv8,
  input  logic          adv16,
  input  logic          pf_we,
  input  logic [AW-1:0] pf_din,
  output logic [AW-1:0] tbl_ptr,
  output logic [AW-1:0] pf_addr,
  output logic [AW-1:0] pf_ptr
);

  localparam logic [AW-1:0] STEP_ONE = AW'(8);
  localparam logic [AW-1:0] STEP_TWO = AW'(16);

  // advance inside the circular table, offset kept below 8*qwords
  function automatic logic [AW-1:0] tbl_wrap(input logic [AW-1:0] b,
                                              input logic [AW-1:0] p,
                                              input logic [AW-1:0] inc,
                                              input logic [CW-1:0] qw);
    logic [AW-1:0] off;
    logic [AW-1:0] span;
    span = AW'({qw, 3'b000});
    off  = p - b + inc;
    if (off >= span) off = off - span;
    return b + off;
  endfunction

  assign pf_addr = tbl_wrap(base, tbl_ptr, STEP_ONE, qwords);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_ptr <= '0;
      pf_ptr  <= '0;
    end else begin
      if (ld_base)    tbl_ptr <= base;
      else if (adv8)  tbl_ptr <= tbl_wrap(base, tbl_ptr, STEP_ONE, qwords);
      else if (adv16) tbl_ptr <= tbl_wrap(base, tbl_ptr, STEP_TWO, qwords);
      if (pf_we) pf_ptr <= pf_din;
    end
  end

endmodule

// File: rtl/rxcd_cluster_ctr.sv
module rxcd_cluster_ctr #(
  parameter int AW = 64,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] limit,
  input  logic          load,
  input  logic [AW-1:0] load_ptr,
  input  logic          step,
  input  logic          save,
  output logic [AW-1:0] clu_ptr,
  output logic [CW-1:0] cnt,
  output logic [AW-1:0] head,
  output logic          at_limit
);

  localparam logic [AW-1:0] QW_BYTES = AW'(8);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  function automatic logic full_check(input logic [CW-1:0] c, input logic [CW-1:0] l);
    return c >= l;
  endfunction

  assign at_limit = full_check(cnt, limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clu_ptr <= '0;
      cnt     <= '0;
      head    <= '0;
    end else begin
      if (load) begin
        clu_ptr <= load_ptr;
        cnt     <= '0;
      end else if (step) begin
        clu_ptr <= clu_ptr + QW_BYTES;
        cnt     <= cnt + CNT_ONE;
      end
      if (save) head <= clu_ptr;
    end
  end

endmodule

// File: rtl/rxcd_ctrl.sv
module rxcd_ctrl
  import rxcd_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          irq_clr,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [63:0]   cmd_data,
  output logic          cmd_ack,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [63:0]   mem_rdata,
  input  logic [AW-1:0] tbl_ptr,
  input  logic [AW-1:0] pf_addr,
  input  logic [AW-1:0] pf_ptr,
  input  logic [AW-1:0] clu_ptr,
  input  logic          at_limit,
  output logic          ld_base,
  output logic          adv8,
  output logic          adv16,
  output logic          pf_we,
  output logic [AW-1:0] pf_din,
  output logic          clu_load,
  output logic [AW-1:0] clu_load_ptr,
  output logic          clu_step,
  output logic          clu_save,
  output logic          irq,
  output logic          ovf,
  output logic          ev_stat_wr,
  output logic          ev_data_wr,
  output logic          ev_irq_set,
  output logic          ev_ovf,
  output logic          run_active
);

  rxcd_state_e st, nxt;
  rxcd_op_e    op;
  logic        intr_pend;
  logic        zero_pend;

  assign op     = rxcd_op_e'(cmd_op);
  assign pf_din = mem_rdata[AW-1:0];

  always_comb begin
    nxt          = st;
    cmd_ack      = 1'b0;
    mem_req      = 1'b0;
    mem_we       = 1'b0;
    mem_addr     = '0;
    mem_wdata    = '0;
    ld_base      = 1'b0;
    adv8         = 1'b0;
    adv16        = 1'b0;
    pf_we        = 1'b0;
    clu_load     = 1'b0;
    clu_load_ptr = '0;
    clu_step     = 1'b0;
    clu_save     = 1'b0;
    ev_irq_set   = 1'b0;
    ev_ovf       = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (start) begin
          ld_base = 1'b1;
          nxt     = ST_FIRST;
        end
      end
      ST_FIRST: begin
        mem_req  = 1'b1;
        mem_addr = tbl_ptr;
        if (mem_ack) begin
          clu_load     = 1'b1;
          clu_load_ptr = mem_rdata[AW-1:0];
          adv8         = 1'b1;
          nxt          = ST_PREF;
        end
      end
      ST_PREF: begin
        mem_req  = 1'b1;
        mem_addr = pf_addr;
        if (mem_ack) begin
          pf_we   = 1'b1;
          cmd_ack = intr_pend;
          nxt     = ST_RUN;
        end
      end
      ST_RUN: begin
        if (cmd_valid) begin
          unique case (op)
            OP_SAVE: begin
              clu_save = 1'b1;
              cmd_ack  = 1'b1;
            end
            OP_SKIP: begin
              cmd_ack = 1'b1;
              if (at_limit) ev_ovf = 1'b1;
              else          clu_step = 1'b1;
            end
            OP_NEXT: begin
              if (at_limit) begin
                ev_ovf  = 1'b1;
                cmd_ack = 1'b1;
              end else begin
                nxt = ST_WDATA;
              end
            end
            OP_STAT: nxt = ST_WSTAT;
            OP_INTR: begin
              ev_irq_set   = 1'b1;
              clu_load     = 1'b1;
              clu_load_ptr = pf_ptr;
              nxt          = ST_PREF;
            end
            default: cmd_ack = 1'b1;
          endcase
        end
      end
      ST_WDATA: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = clu_ptr;
        mem_wdata = zero_pend ? 64'd0 : cmd_data;
        if (mem_ack) begin
          clu_step = 1'b1;
          cmd_ack  = 1'b1;
          nxt      = ST_RUN;
        end
      end
      ST_WSTAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = tbl_ptr;
        mem_wdata = stat_word(cmd_data);
        if (mem_ack) begin
          adv16   = 1'b1;
          cmd_ack = 1'b1;
          nxt     = ST_RUN;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign ev_stat_wr = (st == ST_WSTAT) && mem_req;
  assign ev_data_wr = (st == ST_WDATA) && mem_req;
  assign run_active = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      intr_pend <= 1'b0;
      zero_pend <= 1'b0;
      irq       <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      st <= nxt;
      if (ev_irq_set)          intr_pend <= 1'b1;
      else if (pf_we)          intr_pend <= 1'b0;
      if (st == ST_WSTAT && mem_ack)              zero_pend <= 1'b1;
      else if ((st == ST_WDATA && mem_ack) || ev_irq_set) zero_pend <= 1'b0;
      if (ev_irq_set)   irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
      if (ev_ovf)       ovf <= 1'b1;
      else if (irq_clr) ovf <= 1'b0;
    end
  end

endmodule

// File: rtl/rx_cluster_dma.sv
module rx_cluster_dma #(
  parameter int AW = 64,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          irq_clr,
  input  logic [AW-1:0] cfg_tbl_base,
  input  logic [CW-1:0] cfg_clu_limit,
  input  logic [CW-1:0] cfg_tbl_qwords,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [63:0]   cmd_data,
  output logic          cmd_ack,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [63:0]   mem_rdata,
  output logic [AW-1:0] tbl_pos,
  output logic [AW-1:0] head_ptr,
  output logic          irq,
  output logic          ovf
);

  logic          ld_base, adv8, adv16, pf_we;
  logic [AW-1:0] pf_din, pf_addr, pf_ptr;
  logic          clu_load, clu_step, clu_save, at_limit;
  logic [AW-1:0] clu_load_ptr, clu_ptr;
  logic [CW-1:0] clu_cnt;
  logic          ev_stat_wr, ev_data_wr, ev_irq_set, ev_ovf, run_active;

  rxcd_tbl_walker #(.AW(AW), .CW(CW)) u_walker (
    .clk     (clk),
    .rst_n   (rst_n),
    .base    (cfg_tbl_base),
    .qwords  (cfg_tbl_qwords),
    .ld_base (ld_base),
    .adv8    (adv8),
    .adv16   (adv16),
    .pf_we   (pf_we),
    .pf_din  (pf_din),
    .tbl_ptr (tbl_pos),
    .pf_addr (pf_addr),
    .pf_ptr  (pf_ptr)
  );

  rxcd_cluster_ctr #(.AW(AW), .CW(CW)) u_cluster (
    .clk      (clk),
    .rst_n    (rst_n),
    .limit    (cfg_clu_limit),
    .load     (clu_load),
    .load_ptr (clu_load_ptr),
    .step     (clu_step),
    .save     (clu_save),
    .clu_ptr  (clu_ptr),
    .cnt      (clu_cnt),
    .head     (head_ptr),
    .at_limit (at_limit)
  );

  rxcd_ctrl #(.AW(AW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .irq_clr      (irq_clr),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_data     (cmd_data),
    .cmd_ack      (cmd_ack),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ack      (mem_ack),
    .mem_rdata    (mem_rdata),
    .tbl_ptr      (tbl_pos),
    .pf_addr      (pf_addr),
    .pf_ptr       (pf_ptr),
    .clu_ptr      (clu_ptr),
    .at_limit     (at_limit),
    .ld_base      (ld_base),
    .adv8         (adv8),
    .adv16        (adv16),
    .pf_we        (pf_we),
    .pf_din       (pf_din),
    .clu_load     (clu_load),
    .clu_load_ptr (clu_load_ptr),
    .clu_step     (clu_step),
    .clu_save     (clu_save),
    .irq          (irq),
    .ovf          (ovf),
    .ev_stat_wr   (ev_stat_wr),
    .ev_data_wr   (ev_data_wr),
    .ev_irq_set   (ev_irq_set),
    .ev_ovf       (ev_ovf),
    .run_active   (run_active)
  );

endmodule

// File: rtl/rxcd_chk.sv
module rxcd_chk #(
  parameter int AW = 64,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_clr,
  input logic [AW-1:0] cfg_tbl_base,
  input logic [CW-1:0] cfg_clu_limit,
  input logic [CW-1:0] cfg_tbl_qwords,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [63:0]   mem_wdata,
  input logic [AW-1:0] tbl_pos,
  input logic [CW-1:0] clu_cnt,
  input logic          clu_load,
  input logic          irq,
  input logic          ev_stat_wr,
  input logic          ev_data_wr,
  input logic          ev_irq_set,
  input logic          run_active
);

  logic [AW-1:0] span;
  assign span = AW'({cfg_tbl_qwords, 3'b000});

  p_stat_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stat_wr |-> mem_wdata[3]);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data_wr |-> (clu_cnt < cfg_clu_limit));

  p_tbl_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run_active |-> ((tbl_pos - cfg_tbl_base) < span));

  p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_irq_set |=> irq);

  p_cnt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clu_load |=> (clu_cnt == '0));

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

endmodule

bind rx_cluster_dma rxcd_chk #(.AW(AW), .CW(CW)) u_rxcd_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .irq_clr        (irq_clr),
  .cfg_tbl_base   (cfg_tbl_base),
  .cfg_clu_limit  (cfg_clu_limit),
  .cfg_tbl_qwords (cfg_tbl_qwords),
  .mem_req        (mem_req),
  .mem_ack        (mem_ack),
  .mem_addr       (mem_addr),
  .mem_wdata      (mem_wdata),
  .tbl_pos        (tbl_pos),
  .clu_cnt        (clu_cnt),
  .clu_load       (clu_load),
  .irq            (irq),
  .ev_stat_wr     (ev_stat_wr),
  .ev_data_wr     (ev_data_wr),
  .ev_irq_set     (ev_irq_set),
  .run_active     (run_active)
);

// File: tb/test_rx_cluster_dma.sv
`timescale 1ns/1ps
module test_rx_cluster_dma;

  localparam logic [63:0] BASE = 64'h8000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        irq_clr = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [63:0] cmd_data = 64'd0;
  logic        cmd_ack;
  logic        mem_req, mem_we;
  logic [63:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = 64'd0;
  logic [63:0] tbl_pos, head_ptr;
  logic        irq, ovf;

  int ntests = 0;
  int nfail  = 0;
  int cyc    = 0;

  typedef struct packed {
    logic        we;
    logic [63:0] addr;
    logic [63:0] data;
  } txn_t;
  txn_t expq[$];

  always #2.5 clk = ~clk;

  rx_cluster_dma #(.AW(64), .CW(16)) i_rx_cluster_dma (
    .clk(clk), .rst_n(rst_n), .start(start), .irq_clr(irq_clr),
    .cfg_tbl_base(BASE), .cfg_clu_limit(16'd4), .cfg_tbl_qwords(16'd8),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_ack(cmd_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tbl_pos(tbl_pos), .head_ptr(head_ptr), .irq(irq), .ovf(ovf)
  );

  // table model: entry i holds pointer 0x10000 + i*0x100
  function automatic logic [63:0] tbl_entry(input logic [63:0] a);
    return 64'h10000 + ((a - BASE) >> 4) * 64'h100;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic we, input logic [63:0] a, input logic [63:0] d);
    expq.push_back('{we: we, addr: a, data: d});
  endtask

  task automatic send(input logic [2:0] op, input logic [63:0] d);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_data  = d;
    forever begin
      #1;
      if (cmd_ack) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = 3'd0;
  endtask

  // memory model and scoreboard monitor
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (rst_n && mem_req) begin
      ntests++;
      if (expq.size() == 0) begin
        nfail++;
        $display("FAIL R12 unexpected access actual we=%0d addr=%h expected none", mem_we, mem_addr);
      end else begin
        txn_t e;
        e = expq.pop_front();
        if (mem_we !== e.we || mem_addr !== e.addr || (e.we && mem_wdata !== e.data)) begin
          nfail++;
          $display("FAIL R5 access actual we=%0d addr=%h data=%h expected we=%0d addr=%h data=%h",
                   mem_we, mem_addr, mem_wdata, e.we, e.addr, e.data);
        end
      end
      mem_rdata <= tbl_entry(mem_addr);
      mem_ack   <= 1'b1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset irq", {63'd0, irq}, 64'd0);
    check("reset ovf", {63'd0, ovf}, 64'd0);
    check("reset mem_req", {63'd0, mem_req}, 64'd0);

    // R1 / R2: first pointer fetch then prefetch one entry ahead
    push(1'b0, BASE, 0);
    push(1'b0, BASE + 64'h10, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    check("R1 tbl_pos after start", tbl_pos, BASE + 64'h8);
    check("R2 prefetch done", 64'(expq.size()), 64'd0);

    // packet 1 in cluster 0x10000
    send(3'd1, 0);
    check("R3 head", head_ptr, 64'h10000);
    send(3'd2, 0);                                     // R4 skip
    push(1'b1, 64'h10008, 64'hAAAA_0001);
    send(3'd3, 64'hAAAA_0001);                         // R5
    push(1'b1, 64'h10010, 64'hAAAA_0002);
    send(3'd3, 64'hAAAA_0002);
    push(1'b1, BASE + 64'h8, 64'h5000_0F08);
    send(3'd4, 64'h5000_0F00);                         // R6 bit 3 forced
    check("R6 tbl_pos step", tbl_pos, BASE + 64'h18);
    push(1'b1, 64'h10018, 64'd0);
    send(3'd3, 64'hDEAD_BEEF);                         // R7 zero qword
    push(1'b0, BASE + 64'h20, 0);
    send(3'd5, 0);                                     // R8
    check("R8 irq set", {63'd0, irq}, 64'd1);
    check("R10 ovf before overrun", {63'd0, ovf}, 64'd0);

    // packet 2 in cluster 0x10100: count reset (R8) then overrun (R10)
    for (int i = 0; i < 4; i++) begin
      push(1'b1, 64'h10100 + 64'(i) * 8, 64'hB000 + 64'(i));
      send(3'd3, 64'hB000 + 64'(i));
    end
    send(3'd3, 64'hBAD0);
    check("R10 ovf after overrun", {63'd0, ovf}, 64'd1);
    send(3'd2, 0);
    send(3'd7, 64'h1234);                              // R12 unused codes
    send(3'd0, 64'h1234);
    send(3'd6, 64'h1234);
    check("R12 head unchanged", head_ptr, 64'h10000);
    check("R12 tbl_pos unchanged", tbl_pos, BASE + 64'h18);
    push(1'b1, BASE + 64'h18, 64'h0000_0018);
    send(3'd4, 64'h0000_0010);
    push(1'b0, BASE + 64'h30, 0);
    send(3'd5, 0);
    check("R11 irq held", {63'd0, irq}, 64'd1);
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    check("R11 irq cleared", {63'd0, irq}, 64'd0);
    check("R11 ovf cleared", {63'd0, ovf}, 64'd0);

    // packet 3 in cluster 0x10200, prefetch wraps to table start (R9)
    send(3'd1, 0);
    check("R8 promoted head", head_ptr, 64'h10200);
    push(1'b1, 64'h10200, 64'hC1);
    send(3'd3, 64'hC1);
    push(1'b1, BASE + 64'h28, 64'h2A);
    send(3'd4, 64'h22);
    check("R9 tbl_pos before wrap", tbl_pos, BASE + 64'h38);
    push(1'b0, BASE, 0);
    send(3'd5, 0);

    // packet 4 in cluster 0x10300, status wraps (R9)
    push(1'b1, BASE + 64'h38, 64'hFF);
    send(3'd4, 64'hFF);
    check("R9 tbl_pos wrapped", tbl_pos, BASE + 64'h8);
    push(1'b1, 64'h10300, 64'd0);
    send(3'd3, 64'h77);
    send(3'd1, 0);
    check("R4 R5 pointer after zero write", head_ptr, 64'h10308);
    push(1'b0, BASE + 64'h10, 0);
    send(3'd5, 0);
    check("R8 irq again", {63'd0, irq}, 64'd1);
    repeat (4) @(negedge clk);
    check("R5 scoreboard drained", 64'(expq.size()), 64'd0);

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

endmodule